// File: doc/BRIEF.md
# Timestamped Digital Change Detector

This block watches a bank of asynchronous digital lines. It reports every rising or falling transition on the lines whose edge detection is enabled. Each line first passes through a two-stage synchronizer clocked by the sample clock, which runs at 80 MHz in the target system. A per-line edge detector then flags a change whenever an enabled edge appears on any line.

The first change after the block is armed opens a merge window of a programmable length, from 0 to 255 sample clocks. Further changes inside that window fold into the same record. When the window closes, the synchronized port word at that moment is stored in a small FIFO. The stored entry also carries the value that a free-running tick counter held when the first change was seen. The tick counter advances once every four sample clocks, which is 20 MHz in the target system. The port word and its timestamp always enter the FIFO together as one entry, so the list of events and the list of times can never drift apart. Each detected event also drives a fixed-width pulse on an event output.

A control state machine sequences the block through four states: `ST_IDLE`, `ST_ARMED`, `ST_MERGE` and `ST_DONE`. Its transitions are:
- arm: `start` in any state enters `ST_ARMED` and clears the timestamp, the record count and the overflow flag.
- detect: `ST_ARMED` goes to `ST_MERGE` on an enabled change.
- close: `ST_MERGE` goes back to `ST_ARMED` when the window ends and the record limit has not been reached.
- finish: `ST_MERGE` goes to `ST_DONE` when the window ends, finite mode is on and the record count reaches `rec_limit`.

Top module: `tsdc_top`

## Requirements
- R1: Each input line passes through two synchronizer flops. Suppose a line changes just before sample edge k. The change is then detected in the cycle that ends at edge k+2, and `event_out` is first high after edge k+2.
- R2: Rising-edge detection is enabled per line by `rise_en[n]`, and falling-edge detection by `fall_en[n]`. A transition whose kind is disabled on its line produces no record and no pulse.
- R3: The `rec_data` field of a record is the synchronized port word, with bit n equal to the level of line n. For example, line 0 high alone gives 1, line 3 high alone gives 8, and both high give 9.
- R4: Let j be the number of sample edges after the `start` edge. After edge j the timestamp counter equals floor(j/4). A record's `rec_time` is the counter value held just before the edge that leaves `ST_ARMED`. For a change driven just before edge k, this is floor((k+1)/4).
- R5: Each detected event makes `event_out` high for exactly 12 consecutive sample clocks.
- R6: An event detected while `event_out` is already high still produces its own record. It neither restarts nor lengthens the running pulse.
- R7: Let W be the value of `merge_win`. A second change is merged into the first record when it follows the first change by at most W+1 cycles. A later change starts a new record. The stored word is the port word sampled at the close of the window.
- R8: The 32-bit timestamp counter is cleared by `start`. It advances only in `ST_ARMED` and `ST_MERGE`, and it wraps silently.
- R9: A record that arrives while the FIFO is full is dropped, and `overflow` is set. `overflow` stays set until the next `start`.
- R10: With `finite_mode` set, the block enters `ST_DONE` after `rec_limit` records. It then ignores all changes until `start`, and `armed` is 0 with `done` at 1.
- R11: Records leave the FIFO in arrival order. `rec_valid` is high while the FIFO is not empty. `rec_data` and `rec_time` show the oldest record, and `pop` removes it.
- R12: After reset the state is `ST_IDLE`, and `rec_valid`, `event_out`, `overflow`, `armed` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 8 | Asynchronous digital lines |
| rise_en | input | 8 | Per-line rising-edge enable |
| fall_en | input | 8 | Per-line falling-edge enable |
| start | input | 1 | One-cycle arm pulse; clears the timestamp, the count and the overflow flag |
| finite_mode | input | 1 | 1 = stop after `rec_limit` records |
| rec_limit | input | 16 | Record limit used in finite mode |
| merge_win | input | 8 | Merge window length in sample clocks |
| pop | input | 1 | Remove the oldest record |
| rec_valid | output | 1 | FIFO holds at least one record |
| rec_data | output | 8 | Port word of the oldest record |
| rec_time | output | 32 | Timestamp of the oldest record |
| event_out | output | 1 | Event pulse, 12 sample clocks wide |
| overflow | output | 1 | Sticky flag: a record was dropped |
| armed | output | 1 | State is `ST_ARMED` or `ST_MERGE` |
| done | output | 1 | State is `ST_DONE` |

## Verification
The assertions take for granted that `finite_mode`, `rec_limit`, `merge_win` and the edge enables stay constant while the block is armed. The check that `ST_DONE` implies the limit has been reached is only meaningful under that assumption. They also assume that `start` is a single-cycle pulse and that `pop` is asserted only while `rec_valid` is high. The stimulus respects all of this. It changes configuration only just before a `start` pulse and keeps `start` high for one cycle. It pops only after the bench has seen that a record is present. It drives the lines at falling clock edges, so that every timestamp follows exactly from the drive cycle.

// File: rtl/tsdc_pkg.sv
package tsdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MERGE = 2'd2,
        ST_DONE  = 2'd3
    } tsdc_state_e;
endpackage

// File: rtl/tsdc_sync.sv
module tsdc_sync #(
    parameter int N_LINES = 8,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw,
    output logic [N_LINES-1:0] lvl
);
    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], raw[gi]};
            end
            assign lvl[gi] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tsdc_edge.sv
module tsdc_edge #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lvl,
    input  logic [N_LINES-1:0] rise_en,
    input  logic [N_LINES-1:0] fall_en,
    output logic               change
);
    logic [N_LINES-1:0] prev;
    logic [N_LINES-1:0] hits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    always_comb begin
        hits   = (lvl & ~prev & rise_en) | (~lvl & prev & fall_en);
        change = |hits;
    end
endmodule

// File: rtl/tsdc_tstamp.sv
module tsdc_tstamp #(
    parameter int TS_W     = 32,
    parameter int TICK_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    output logic [TS_W-1:0] ts
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0] div;
    logic          tick;

    assign tick = run && (div == DIV_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div <= '0;
            ts  <= '0;
        end else if (clear) begin
            div <= '0;
            ts  <= '0;
        end else if (run) begin
            div <= tick ? '0 : div + 1'b1;
            if (tick) ts <= ts + 1'b1;
        end
    end

    // R8
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(ts));

    // R4
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (ts == $past(ts)) || (ts == $past(ts) + 1'b1));
endmodule

// File: rtl/tsdc_fifo.sv
module tsdc_fifo #(
    parameter int DW    = 40,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    input  logic          clr_ovf,
    output logic [DW-1:0] rdata,
    output logic          not_empty,
    output logic          overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          full, push_ok, pop_ok;

    assign full      = (cnt == FULL_CNT);
    assign not_empty = (cnt != '0);
    assign push_ok   = push && !full;
    assign pop_ok    = pop && not_empty;
    assign rdata     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
            if (clr_ovf)           overflow <= 1'b0;
            else if (push && full) overflow <= 1'b1;
        end
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr_ovf) |=> overflow);

    // R9
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R11
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);
endmodule

// File: rtl/tsdc_ctrl.sv
module tsdc_ctrl
    import tsdc_pkg::*;
#(
    parameter int WIN_W     = 8,
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             change,
    input  logic             finite_mode,
    input  logic [CNT_W-1:0] rec_limit,
    input  logic [WIN_W-1:0] merge_win,
    output logic             detect,
    output logic             commit,
    output logic             armed,
    output logic             done,
    output logic             event_out
);
    localparam int PW = $clog2(PULSE_LEN + 1);
    localparam logic [PW-1:0] PULSE_INIT = PW'(PULSE_LEN);

    tsdc_state_e      state, state_nx;
    logic [WIN_W-1:0] wcnt;
    logic [CNT_W-1:0] rec_cnt;
    logic [CNT_W:0]   rec_cnt_inc;
    logic [PW-1:0]    pulse_cnt;
    logic             win_end, reach_limit;

    assign win_end     = (wcnt == merge_win);
    assign rec_cnt_inc = {1'b0, rec_cnt} + 1'b1;
    assign reach_limit = finite_mode && (rec_cnt_inc >= {1'b0, rec_limit});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (start)       state_nx = ST_ARMED;
                else if (change) state_nx = ST_MERGE;
            end
            ST_MERGE: begin
                if (start)        state_nx = ST_ARMED;
                else if (win_end) state_nx = reach_limit ? ST_DONE : ST_ARMED;
            end
            ST_DONE:  if (start) state_nx = ST_ARMED;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        detect = 1'b0;
        commit = 1'b0;
        armed  = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ARMED: begin
                armed  = 1'b1;
                detect = change && !start;
            end
            ST_MERGE: begin
                armed  = 1'b1;
                commit = win_end && !start;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
        event_out = (pulse_cnt != '0);
    end

    // merge window, record count and pulse counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt      <= '0;
            rec_cnt   <= '0;
            pulse_cnt <= '0;
        end else begin
            if (detect)                wcnt <= '0;
            else if (state == ST_MERGE) wcnt <= wcnt + 1'b1;

            if (start)       rec_cnt <= '0;
            else if (commit) rec_cnt <= rec_cnt_inc[CNT_W-1:0];

            if (detect && (pulse_cnt == '0)) pulse_cnt <= PULSE_INIT;
            else if (pulse_cnt != '0)        pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    // R5
    evt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(event_out) |-> $past(detect));

    // R6
    evt_noretrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_out && detect) |=> (pulse_cnt == $past(pulse_cnt) - 1'b1));

    // R10
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (rec_cnt >= rec_limit));

    // R7
    commit_after_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state != ST_MERGE));
endmodule

// File: rtl/tsdc_top.sv
module tsdc_top #(
    parameter int N_LINES    = 8,
    parameter int TS_W       = 32,
    parameter int TICK_DIV   = 4,
    parameter int PULSE_LEN  = 12,
    parameter int WIN_W      = 8,
    parameter int CNT_W      = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] din,
    input  logic [N_LINES-1:0] rise_en,
    input  logic [N_LINES-1:0] fall_en,
    input  logic               start,
    input  logic               finite_mode,
    input  logic [CNT_W-1:0]   rec_limit,
    input  logic [WIN_W-1:0]   merge_win,
    input  logic               pop,
    output logic               rec_valid,
    output logic [N_LINES-1:0] rec_data,
    output logic [TS_W-1:0]    rec_time,
    output logic               event_out,
    output logic               overflow,
    output logic               armed,
    output logic               done
);
    localparam int REC_W = TS_W + N_LINES;

    logic [N_LINES-1:0] lvl;
    logic               change, detect, commit;
    logic [TS_W-1:0]    ts, ts_cap;
    logic [REC_W-1:0]   rec_in, rec_out;

    tsdc_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(din), .lvl(lvl)
    );

    tsdc_edge #(.N_LINES(N_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl),
        .rise_en(rise_en), .fall_en(fall_en), .change(change)
    );

    tsdc_ctrl #(.WIN_W(WIN_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .change(change),
        .finite_mode(finite_mode), .rec_limit(rec_limit), .merge_win(merge_win),
        .detect(detect), .commit(commit), .armed(armed), .done(done),
        .event_out(event_out)
    );

    tsdc_tstamp #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_ts (
        .clk(clk), .rst_n(rst_n), .clear(start), .run(armed), .ts(ts)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ts_cap <= '0;
        else if (detect) ts_cap <= ts;
    end

    assign rec_in = {ts_cap, lvl};

    tsdc_fifo #(.DW(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(commit), .wdata(rec_in),
        .pop(pop), .clr_ovf(start), .rdata(rec_out),
        .not_empty(rec_valid), .overflow(overflow)
    );

    assign rec_data = rec_out[N_LINES-1:0];
    assign rec_time = rec_out[REC_W-1:N_LINES];

    // R11
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !overflow && !pop) |=> rec_valid);
endmodule

// File: tb/tb_tsdc_top.sv
module tb_tsdc_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  din, rise_en, fall_en;
    logic        start, finite_mode, pop;
    logic [15:0] rec_limit;
    logic [7:0]  merge_win;
    logic        rec_valid, event_out, overflow, armed, done;
    logic [7:0]  rec_data;
    logic [31:0] rec_time;

    int     tests = 0, fails = 0, evcnt = 0;
    longint tp0 = 0;
    bit     finished = 0;

    always #10 clk = ~clk;

    tsdc_top dut (
        .clk(clk), .rst_n(rst_n), .din(din), .rise_en(rise_en), .fall_en(fall_en),
        .start(start), .finite_mode(finite_mode), .rec_limit(rec_limit),
        .merge_win(merge_win), .pop(pop), .rec_valid(rec_valid), .rec_data(rec_data),
        .rec_time(rec_time), .event_out(event_out), .overflow(overflow),
        .armed(armed), .done(done)
    );

    always @(posedge clk) begin
        #2;
        if (event_out) evcnt++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input bit fin, input int lim, input int win);
        @(negedge clk);
        finite_mode = fin;
        rec_limit   = 16'(lim);
        merge_win   = 8'(win);
        start       = 1'b1;
        tp0         = $time + 10;
        @(negedge clk);
        start = 1'b0;
    endtask

    // drive one line at a falling edge; k = index of the next rising edge since start
    task automatic drive(input int ln, input bit v, output longint k);
        @(negedge clk);
        din[ln] = v;
        k = ($time + 10 - tp0) / 20;
    endtask

    task automatic pop_chk(input string req, input int data, input longint t);
        @(negedge clk);
        chk({req, " valid"}, longint'(rec_valid), 1);
        chk({req, " data"},  longint'(rec_data), data);
        chk({req, " time"},  longint'(rec_time), t);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        longint k, k2;
        longint ks [10];
        int     e0;
        int     wins [3] = '{0, 1, 3};

        rst_n = 1'b0; din = '0; rise_en = '0; fall_en = '0;
        start = 1'b0; finite_mode = 1'b0; rec_limit = '0; merge_win = '0; pop = 1'b0;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        // R12 reset state
        chk("R12 rec_valid", longint'(rec_valid), 0);
        chk("R12 event_out", longint'(event_out), 0);
        chk("R12 overflow",  longint'(overflow), 0);
        chk("R12 armed",     longint'(armed), 0);
        chk("R12 done",      longint'(done), 0);

        // lone event: latency, pulse width, data, time
        rise_en = 8'hFF; fall_en = 8'h00;
        arm(0, 0, 0);
        chk("R8 armed after start", longint'(armed), 1);
        idle(5);
        e0 = evcnt;
        drive(5, 1'b1, k);
        @(negedge clk); chk("R1 no pulse after edge k", longint'(event_out), 0);
        @(negedge clk); chk("R1 no pulse after edge k+1", longint'(event_out), 0);
        @(negedge clk); chk("R1 pulse after edge k+2", longint'(event_out), 1);
        idle(25);
        chk("R5 pulse width", longint'(evcnt - e0), 12);
        pop_chk("R3 R4 lone record", 32, (k + 1) / 4);
        drive(5, 1'b0, k);
        idle(20);
        chk("R2 disabled fall gives no record", longint'(rec_valid), 0);

        // whole port word in one change
        arm(0, 0, 0);
        idle(3);
        @(negedge clk); din = 8'hA5; k = ($time + 10 - tp0) / 20;
        idle(20);
        pop_chk("R3 port word", 8'hA5, (k + 1) / 4);
        @(negedge clk); din = 8'h00;
        idle(10);

        // merge window sweep
        for (int wi = 0; wi < 3; wi++) begin
            for (int g = 1; g <= wins[wi] + 3; g++) begin
                arm(0, 0, wins[wi]);
                idle(3 + g);
                e0 = evcnt;
                drive(0, 1'b1, k);
                repeat (g - 1) @(negedge clk);
                drive(3, 1'b1, k2);
                idle(30);
                chk("R6 single pulse for pair", longint'(evcnt - e0), 12);
                if (g <= wins[wi] + 1) begin
                    pop_chk("R7 merged record", 9, (k + 1) / 4);
                end else begin
                    pop_chk("R7 R6 first record", 1, (k + 1) / 4);
                    pop_chk("R7 R6 second record", 9, (k2 + 1) / 4);
                end
                @(negedge clk);
                chk("R7 no extra record", longint'(rec_valid), 0);
                din = 8'h00;
                idle(10);
            end
        end

        // per-line falling enable only
        rise_en = 8'h00; fall_en = 8'h08;
        arm(0, 0, 0);
        idle(3);
        e0 = evcnt;
        drive(3, 1'b1, k);
        drive(0, 1'b1, k);
        idle(20);
        chk("R2 disabled rise no record", longint'(rec_valid), 0);
        chk("R2 disabled rise no pulse", longint'(evcnt - e0), 0);
        drive(0, 1'b0, k);
        idle(20);
        chk("R2 fall on disabled line", longint'(rec_valid), 0);
        drive(3, 1'b0, k);
        idle(20);
        pop_chk("R2 enabled fall record", 0, (k + 1) / 4);

        // finite mode: limit 3 of 5 toggles
        rise_en = 8'hFF; fall_en = 8'hFF;
        arm(1, 3, 0);
        for (int i = 0; i < 5; i++) begin
            drive(0, (i % 2) == 0, ks[i]);
            idle(19);
        end
        chk("R10 done", longint'(done), 1);
        chk("R10 not armed", longint'(armed), 0);
        for (int i = 0; i < 3; i++)
            pop_chk("R10 finite record", (i % 2) == 0 ? 1 : 0, (ks[i] + 1) / 4);
        @(negedge clk);
        chk("R10 nothing after limit", longint'(rec_valid), 0);
        din = 8'h00;
        idle(5);

        // overflow: 10 records into depth 8
        arm(0, 0, 0);
        chk("R9 overflow clear after start", longint'(overflow), 0);
        for (int i = 0; i < 10; i++) begin
            drive(0, (i % 2) == 0, ks[i]);
            idle(19);
        end
        chk("R9 overflow set", longint'(overflow), 1);
        for (int i = 0; i < 8; i++)
            pop_chk("R11 R9 fifo order", (i % 2) == 0 ? 1 : 0, (ks[i] + 1) / 4);
        @(negedge clk);
        chk("R9 dropped records absent", longint'(rec_valid), 0);
        chk("R9 overflow sticky", longint'(overflow), 1);
        arm(0, 0, 0);
        chk("R9 overflow cleared by start", longint'(overflow), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule